// File: doc/BRIEF.md
# UART Interrupt and DMA Request Controller

This block holds the seven status flags of a UART whose receive side buffers up to two bytes and whose transmit side buffers one byte. The UART datapath feeds it single-cycle event strobes: a received byte entering the buffer, a transmit byte moving to the shifter, a stop bit leaving the line, and framing, parity and overrun detections. CPU accesses arrive as strobes as well: a write-1-to-clear of the flag register, writes of the interrupt enable register and of each DMA channel's enable register, a receive data read that carries the error tag of the byte being read, and a transmit data write.

From the flags and enables it builds one combined interrupt request and, for each DMA channel, a receive request and a transmit request. Only the receive-one-byte flag and the transmit-empty flag can drive DMA. A flag that any channel claims for DMA is masked out of the interrupt. A software reset strobe returns the flags and the receive occupancy to their idle values. The enable registers are cleared only by the hardware reset.

Top module: `uart_evt_ctrl`

## Requirements
- R1: After the hardware reset, flags_o is 7'b0000001 (only bit 0, transmit empty, is set), irq_o is 0, and every DMA request is 0. All enables reset to 0. Flag bits: 0 transmit empty, 1 end of transmission, 2 receive one byte, 3 receive two bytes, 4 overrun, 5 parity, 6 framing.
- R2: Bit 0 sets in the cycle after tx_load_i. It clears in the cycle after tx_wr_i. A write-1-to-clear has no effect on it.
- R3: Bit 1 sets in the cycle after stop_sent_i if bit 0 was 1 in that cycle. It stays unchanged when bit 0 was 0. It clears on flag_w1c_i with wdata_i[1]=1.
- R4: A counter of 0 to 2 tracks receive occupancy. rx_load_i adds one and saturates at 2. rx_rd_i removes one and does nothing when the count is 0. A load and a read in the same cycle leave the count unchanged, except that a count of 0 becomes 1. Bit 2 is count≥1 and bit 3 is count=2, so a read at count 2 leaves bit 2 set and clears bit 3. Write-1-to-clear does not affect bits 2 and 3.
- R5: Bit 6 sets on frm_err_i and bit 5 sets on par_err_i. Bit 6 clears on a write-1-to-clear of bit 6, or on rx_rd_i with rx_rd_frm_i=1. Bit 5 clears on a write-1-to-clear of bit 5, or on rx_rd_i with rx_rd_par_i=1.
- R6: Bit 4 sets on ovr_err_i. It clears only on a write-1-to-clear of bit 4. Receive reads do not clear it.
- R7: When a set event and a clear event reach the same flag in the same cycle, the flag ends up set. Writing 0 to a flag bit leaves that flag unchanged.
- R8: soft_rst_i clears bits 1 to 6, empties the receive count and sets bit 0, with priority over every event. It leaves the interrupt and DMA enables unchanged.
- R9: irq_en_we_i loads wdata_i into the interrupt enable register. irq_o is 1 exactly when some flag is set, its enable bit is set, and the flag is not claimed for DMA.
- R10: dma_en_we_i[c] loads wdata_i[1:0] into channel c's enables: bit 0 enables receive, bit 1 enables transmit. dma_rx_req_o[c] is bit 2 AND the channel's receive enable. dma_tx_req_o[c] is bit 0 AND the channel's transmit enable.
- R11: If any channel enables DMA for bit 2, bit 2 is removed from the interrupt. The same holds for bit 0 and the transmit enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| soft_rst_i | input | 1 | Software reset strobe |
| rx_load_i | input | 1 | Received byte loaded into buffer |
| rx_rd_i | input | 1 | CPU read of receive data |
| rx_rd_frm_i | input | 1 | Byte being read carried a framing error |
| rx_rd_par_i | input | 1 | Byte being read carried a parity error |
| tx_load_i | input | 1 | Transmit byte moved to shifter |
| tx_wr_i | input | 1 | CPU write of transmit data |
| stop_sent_i | input | 1 | Stop bit has been sent |
| frm_err_i | input | 1 | Framing error detected |
| par_err_i | input | 1 | Parity error detected |
| ovr_err_i | input | 1 | Overrun detected |
| wdata_i | input | 7 | Write data for flag clear and enable writes |
| flag_w1c_i | input | 1 | Write-1-to-clear of flag register |
| irq_en_we_i | input | 1 | Interrupt enable register write |
| dma_en_we_i | input | NUM_CH | Per-channel DMA enable write |
| flags_o | output | 7 | Flag register |
| irq_o | output | 1 | Combined interrupt request |
| dma_rx_req_o | output | NUM_CH | Per-channel receive DMA request |
| dma_tx_req_o | output | NUM_CH | Per-channel transmit DMA request |

## Verification
The bench drives a read at full occupancy and checks that the design keeps the one-byte flag and drops only the two-byte flag. It also drives a read and a load together on an empty buffer; a count that wraps or loses the load would show a wrong flag pair. It fires set and clear strobes at the same flag in the same cycle, where a clear-priority design would lose the event. It checks that error-tagged reads clear framing and parity but not overrun. Further cases cover a stop bit arriving while the transmit buffer is full, a soft reset that must keep the enables, and a flag claimed by DMA that must not also raise the interrupt.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int NFLAG    = 7;
  localparam int FB_TXE   = 0;
  localparam int FB_TXEND = 1;
  localparam int FB_RX1   = 2;
  localparam int FB_RX2   = 3;
  localparam int FB_OVR   = 4;
  localparam int FB_PAR   = 5;
  localparam int FB_FRM   = 6;
  localparam int RX_SLOTS = 2;
  localparam int CNT_W    = $clog2(RX_SLOTS + 1);
endpackage

// File: rtl/uart_rx_occupancy.sv
module uart_rx_occupancy
  import uart_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic load_i,
  input  logic rd_i,
  output logic one_o,
  output logic full_o
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(RX_SLOTS);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i && !rd_i) begin
      if (cnt_q != MAXC) cnt_d = cnt_q + CNT_W'(1);
    end else if (rd_i && !load_i) begin
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end else if (rd_i && load_i && cnt_q == '0) begin
      cnt_d = CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (soft_rst_i) cnt_q <= '0;
    else                 cnt_q <= cnt_d;
  end

  assign one_o  = (cnt_q != '0);
  assign full_o = (cnt_q == MAXC);

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAXC);
  // R4
  rd_at_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && rd_i && !load_i && !soft_rst_i) |=> (one_o && !full_o));
endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic tx_load_i,
  input  logic tx_wr_i,
  input  logic stop_sent_i,
  input  logic frm_err_i,
  input  logic par_err_i,
  input  logic ovr_err_i,
  input  logic rx_rd_i,
  input  logic rx_rd_frm_i,
  input  logic rx_rd_par_i,
  input  logic clr_txend_i,
  input  logic clr_ovr_i,
  input  logic clr_par_i,
  input  logic clr_frm_i,
  output logic txe_o,
  output logic txend_o,
  output logic ovr_o,
  output logic par_o,
  output logic frm_o
);
  logic txe_q, txend_q, ovr_q, par_q, frm_q;
  logic set_txend, kill_par, kill_frm;

  assign set_txend = stop_sent_i && txe_q;
  assign kill_par  = clr_par_i || (rx_rd_i && rx_rd_par_i);
  assign kill_frm  = clr_frm_i || (rx_rd_i && rx_rd_frm_i);

  // set beats clear in every flag below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txe_q <= 1'b1; txend_q <= 1'b0; ovr_q <= 1'b0; par_q <= 1'b0; frm_q <= 1'b0;
    end else if (soft_rst_i) begin
      txe_q <= 1'b1; txend_q <= 1'b0; ovr_q <= 1'b0; par_q <= 1'b0; frm_q <= 1'b0;
    end else begin
      if (tx_load_i)      txe_q <= 1'b1;
      else if (tx_wr_i)   txe_q <= 1'b0;
      if (set_txend)      txend_q <= 1'b1;
      else if (clr_txend_i) txend_q <= 1'b0;
      if (ovr_err_i)      ovr_q <= 1'b1;
      else if (clr_ovr_i) ovr_q <= 1'b0;
      if (par_err_i)      par_q <= 1'b1;
      else if (kill_par)  par_q <= 1'b0;
      if (frm_err_i)      frm_q <= 1'b1;
      else if (kill_frm)  frm_q <= 1'b0;
    end
  end

  assign txe_o   = txe_q;
  assign txend_o = txend_q;
  assign ovr_o   = ovr_q;
  assign par_o   = par_q;
  assign frm_o   = frm_q;

  // R3
  txend_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txend_q && !(stop_sent_i && txe_q)) |=> !txend_q);
  // R6
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !soft_rst_i && !clr_ovr_i) |=> ovr_q);
  // R7
  txe_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_i && tx_wr_i) |=> txe_q);
endmodule

// File: rtl/uart_req_route.sv
module uart_req_route
  import uart_evt_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [NFLAG-1:0]  flags_i,
  input  logic [NFLAG-1:0]  irq_en_i,
  input  logic [NUM_CH-1:0] rx_en_i,
  input  logic [NUM_CH-1:0] tx_en_i,
  output logic              irq_o,
  output logic [NUM_CH-1:0] rx_req_o,
  output logic [NUM_CH-1:0] tx_req_o
);
  logic [NFLAG-1:0] dma_claim;

  always_comb begin
    dma_claim         = '0;
    dma_claim[FB_RX1] = |rx_en_i;
    dma_claim[FB_TXE] = |tx_en_i;
  end

  assign irq_o = |(flags_i & irq_en_i & ~dma_claim);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rx_req_o[c] = flags_i[FB_RX1] & rx_en_i[c];
    assign tx_req_o[c] = flags_i[FB_TXE] & tx_en_i[c];
  end

  // R9
  irq_source_chk: assert final (!irq_o || (|(flags_i & irq_en_i)));
  // R10
  dma_source_chk: assert final ((rx_req_o == '0 || flags_i[FB_RX1]) && (tx_req_o == '0 || flags_i[FB_TXE]));
endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
  import uart_evt_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              rx_load_i,
  input  logic              rx_rd_i,
  input  logic              rx_rd_frm_i,
  input  logic              rx_rd_par_i,
  input  logic              tx_load_i,
  input  logic              tx_wr_i,
  input  logic              stop_sent_i,
  input  logic              frm_err_i,
  input  logic              par_err_i,
  input  logic              ovr_err_i,
  input  logic [NFLAG-1:0]  wdata_i,
  input  logic              flag_w1c_i,
  input  logic              irq_en_we_i,
  input  logic [NUM_CH-1:0] dma_en_we_i,
  output logic [NFLAG-1:0]  flags_o,
  output logic              irq_o,
  output logic [NUM_CH-1:0] dma_rx_req_o,
  output logic [NUM_CH-1:0] dma_tx_req_o
);
  logic [NFLAG-1:0]  irq_en_q;
  logic [NUM_CH-1:0] rx_en_q, tx_en_q;
  logic txe, txend, ovr, par, frm, rx1, rx2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          irq_en_q <= '0;
    else if (irq_en_we_i) irq_en_q <= wdata_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dma_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_en_q[c] <= 1'b0;
        tx_en_q[c] <= 1'b0;
      end else if (dma_en_we_i[c]) begin
        rx_en_q[c] <= wdata_i[0];
        tx_en_q[c] <= wdata_i[1];
      end
    end
  end

  uart_rx_occupancy u_occ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .load_i     (rx_load_i),
    .rd_i       (rx_rd_i),
    .one_o      (rx1),
    .full_o     (rx2)
  );

  uart_flag_bank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .tx_load_i   (tx_load_i),
    .tx_wr_i     (tx_wr_i),
    .stop_sent_i (stop_sent_i),
    .frm_err_i   (frm_err_i),
    .par_err_i   (par_err_i),
    .ovr_err_i   (ovr_err_i),
    .rx_rd_i     (rx_rd_i),
    .rx_rd_frm_i (rx_rd_frm_i),
    .rx_rd_par_i (rx_rd_par_i),
    .clr_txend_i (flag_w1c_i && wdata_i[FB_TXEND]),
    .clr_ovr_i   (flag_w1c_i && wdata_i[FB_OVR]),
    .clr_par_i   (flag_w1c_i && wdata_i[FB_PAR]),
    .clr_frm_i   (flag_w1c_i && wdata_i[FB_FRM]),
    .txe_o       (txe),
    .txend_o     (txend),
    .ovr_o       (ovr),
    .par_o       (par),
    .frm_o       (frm)
  );

  always_comb begin
    flags_o           = '0;
    flags_o[FB_TXE]   = txe;
    flags_o[FB_TXEND] = txend;
    flags_o[FB_RX1]   = rx1;
    flags_o[FB_RX2]   = rx2;
    flags_o[FB_OVR]   = ovr;
    flags_o[FB_PAR]   = par;
    flags_o[FB_FRM]   = frm;
  end

  uart_req_route #(.NUM_CH(NUM_CH)) u_route (
    .flags_i  (flags_o),
    .irq_en_i (irq_en_q),
    .rx_en_i  (rx_en_q),
    .tx_en_i  (tx_en_q),
    .irq_o    (irq_o),
    .rx_req_o (dma_rx_req_o),
    .tx_req_o (dma_tx_req_o)
  );

  // R8
  soft_rst_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (flags_o == 7'b0000001));
  // R11
  claim_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_en_q && flags_o[6:1] == '0) |-> !irq_o);
endmodule

// File: tb/uart_evt_ctrl_test.sv
module uart_evt_ctrl_test;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic soft_rst, rx_load, rx_rd, rd_frm, rd_par, tx_load, tx_wr, stop_sent;
  logic frm_err, par_err, ovr_err, w1c, irq_we;
  logic [6:0] wdata;
  logic [NCH-1:0] dma_we;
  logic [6:0] flags;
  logic irq;
  logic [NCH-1:0] rx_req, tx_req;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  int m_txe, m_txend, m_cnt, m_ovr, m_par, m_frm;
  int m_irq_en;
  int m_rx_en [NCH];
  int m_tx_en [NCH];

  always #5 clk = ~clk;

  uart_evt_ctrl #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst),
    .rx_load_i(rx_load), .rx_rd_i(rx_rd), .rx_rd_frm_i(rd_frm), .rx_rd_par_i(rd_par),
    .tx_load_i(tx_load), .tx_wr_i(tx_wr), .stop_sent_i(stop_sent),
    .frm_err_i(frm_err), .par_err_i(par_err), .ovr_err_i(ovr_err),
    .wdata_i(wdata), .flag_w1c_i(w1c), .irq_en_we_i(irq_we), .dma_en_we_i(dma_we),
    .flags_o(flags), .irq_o(irq), .dma_rx_req_o(rx_req), .dma_tx_req_o(tx_req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_flags();
    return m_txe | (m_txend << 1) | ((m_cnt >= 1) << 2) | ((m_cnt == 2) << 3)
         | (m_ovr << 4) | (m_par << 5) | (m_frm << 6);
  endfunction

  function automatic int m_irq();
    int mask = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m_rx_en[c] != 0) mask |= 4;
      if (m_tx_en[c] != 0) mask |= 1;
    end
    return ((m_flags() & m_irq_en & ~mask) != 0) ? 1 : 0;
  endfunction

  task automatic compare_all();
    int f = m_flags();
    chk("R2 txe", int'(flags[0]), f & 1);
    chk("R3 txend", int'(flags[1]), (f >> 1) & 1);
    chk("R4 rx1", int'(flags[2]), (f >> 2) & 1);
    chk("R4 rx2", int'(flags[3]), (f >> 3) & 1);
    chk("R6 ovr", int'(flags[4]), (f >> 4) & 1);
    chk("R5 par", int'(flags[5]), (f >> 5) & 1);
    chk("R5 frm", int'(flags[6]), (f >> 6) & 1);
    chk("R9/R11 irq", int'(irq), m_irq());
    for (int c = 0; c < NCH; c++) begin
      chk("R10 rxreq", int'(rx_req[c]), ((f >> 2) & 1) & m_rx_en[c]);
      chk("R10 txreq", int'(tx_req[c]), (f & 1) & m_tx_en[c]);
    end
  endtask

  task automatic idle();
    soft_rst = 0; rx_load = 0; rx_rd = 0; rd_frm = 0; rd_par = 0;
    tx_load = 0; tx_wr = 0; stop_sent = 0; frm_err = 0; par_err = 0;
    ovr_err = 0; w1c = 0; irq_we = 0; dma_we = '0; wdata = '0;
  endtask

  task automatic model_reset();
    m_txe = 1; m_txend = 0; m_cnt = 0; m_ovr = 0; m_par = 0; m_frm = 0;
  endtask

  // model update from current inputs, advance one clock, compare
  task automatic tick();
    int wd = int'(wdata);
    if (soft_rst) model_reset();
    else begin
      int ntxe = tx_load ? 1 : (tx_wr ? 0 : m_txe);
      int ntxend = (stop_sent && m_txe != 0) ? 1 : ((w1c && wd[1]) ? 0 : m_txend);
      if (rx_load && !rx_rd) m_cnt = (m_cnt < 2) ? m_cnt + 1 : 2;
      else if (rx_rd && !rx_load) m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      else if (rx_rd && rx_load && m_cnt == 0) m_cnt = 1;
      m_ovr = ovr_err ? 1 : ((w1c && wd[4]) ? 0 : m_ovr);
      m_par = par_err ? 1 : (((w1c && wd[5]) || (rx_rd && rd_par)) ? 0 : m_par);
      m_frm = frm_err ? 1 : (((w1c && wd[6]) || (rx_rd && rd_frm)) ? 0 : m_frm);
      m_txe = ntxe; m_txend = ntxend;
    end
    if (irq_we) m_irq_en = wd;
    for (int c = 0; c < NCH; c++)
      if (dma_we[c]) begin m_rx_en[c] = wd & 1; m_tx_en[c] = (wd >> 1) & 1; end
    @(negedge clk);
    idle();
    compare_all();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    model_reset();
    m_irq_en = 0;
    for (int c = 0; c < NCH; c++) begin m_rx_en[c] = 0; m_tx_en[c] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 flags", int'(flags), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma", int'({rx_req, tx_req}), 0);

    // R7: set and clear together on transmit empty
    tx_wr = 1; tx_load = 1; tick();
    chk("R7 txe set wins", int'(flags[0]), 1);
    stop_sent = 1; tick();
    stop_sent = 1; w1c = 1; wdata = 7'h02; tick();
    chk("R7 txend set wins", int'(flags[1]), 1);
    w1c = 1; wdata = 7'h00; tick();
    chk("R7 write 0 no effect", int'(flags[1]), 1);
    w1c = 1; wdata = 7'h0D; tick();
    chk("R2 w1c ignored on txe", int'(flags[0]), 1);
    // R3: stop bit while buffer full
    w1c = 1; wdata = 7'h02; tx_wr = 1; tick();
    stop_sent = 1; tick();
    chk("R3 no set when txe=0", int'(flags[1]), 0);

    // R4: occupancy corners
    rx_load = 1; rx_rd = 1; tick();
    chk("R4 load+read at 0", int'(flags[3:2]), 1);
    rx_load = 1; tick();
    rx_load = 1; tick();
    chk("R4 saturated", int'(flags[3:2]), 3);
    rx_rd = 1; tick();
    chk("R4 read at two", int'(flags[3:2]), 1);
    rx_rd = 1; tick(); rx_rd = 1; tick();
    chk("R4 read at empty", int'(flags[3:2]), 0);

    // R5 / R6: error clears
    ovr_err = 1; par_err = 1; frm_err = 1; tick();
    rx_rd = 1; rd_par = 1; rd_frm = 1; tick();
    chk("R5 tagged read clears", int'(flags[6:5]), 0);
    chk("R6 read keeps ovr", int'(flags[4]), 1);
    w1c = 1; wdata = 7'h10; tick();
    chk("R6 w1c clears ovr", int'(flags[4]), 0);

    // R8: soft reset keeps enables
    irq_we = 1; wdata = 7'h01; tick();
    ovr_err = 1; rx_load = 1; tick();
    soft_rst = 1; rx_load = 1; ovr_err = 1; tick();
    chk("R8 flags", int'(flags), 1);
    chk("R8 enable kept", int'(irq), 1);

    // R10 / R11: DMA claim masks interrupt
    dma_we = 2'b01; wdata = 7'h02; tick();
    chk("R11 masked", int'(irq), 0);
    chk("R10 tx req ch0", int'(tx_req), 1);
    dma_we = 2'b11; wdata = 7'h00; tick();
    chk("R11 released", int'(irq), 1);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      soft_rst  = ($urandom_range(99) < 2);
      rx_load   = ($urandom_range(99) < 30);
      rx_rd     = ($urandom_range(99) < 30);
      rd_frm    = $urandom_range(1);
      rd_par    = $urandom_range(1);
      tx_load   = ($urandom_range(99) < 25);
      tx_wr     = ($urandom_range(99) < 25);
      stop_sent = ($urandom_range(99) < 25);
      frm_err   = ($urandom_range(99) < 10);
      par_err   = ($urandom_range(99) < 10);
      ovr_err   = ($urandom_range(99) < 10);
      w1c       = ($urandom_range(99) < 15);
      irq_we    = ($urandom_range(99) < 5);
      for (int c = 0; c < NCH; c++) dma_we[c] = ($urandom_range(99) < 5);
      wdata     = 7'($urandom_range(127));
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule